// File: doc/BRIEF.md
# Accumulator readout formatter

This block turns a 64-bit multiply-accumulate accumulator into a 32-bit register result. A 2-bit mode selects one of three views of the accumulator. The fractional view shifts and rounds, then optionally clamps to a 16-bit or 32-bit range. The signed integer view clamps the value to the signed 32-bit range. The unsigned integer view clamps it to the unsigned 32-bit range.

The control pins are plain, single-bit levels: a half-width select, a rounding enable and a saturation enable. They are sampled together with the accumulator and the mode on the clock edge where the read strobe is high. The formatted word appears on the output one cycle after the strobe and stays there until the next strobe. There is no back-pressure: a strobe is always accepted, and the consumer takes the result whenever it needs it.

Top module: `acc_readout_fmt`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `rd_data` is 0.
- R2: `rd_data` loads a new result only on a rising clock edge where `rd_stb` is 1. The result is computed from the inputs sampled at that edge. When `rd_stb` is 0, `rd_data` holds its value and ignores changes on every other input.
- R3: Fractional mode (`rd_mode` = 0) with `frac_half` = 1 keeps accumulator bits 39..24 as a 16-bit value. It rounds that value on bits 23..0 by round-half-to-even: above 0x800000 it adds one, and at exactly 0x800000 it adds one only when the kept value is odd. `frac_round` is ignored here. Bits 63..40 do not affect the result, and `rd_data[31:16]` is 0.
- R4: Fractional mode with `frac_half` = 0 and `frac_round` = 1 takes the accumulator shifted right by 8. It rounds on bits 7..0 by round-half-to-even: above 0x80 it adds one, and at exactly 0x80 it adds one only when the shifted value is odd.
- R5: Fractional mode with `frac_half` = 0 and `frac_round` = 0 truncates the accumulator shifted right by 8.
- R6: In half-width fractional mode, rounding can carry into bit 16. With `frac_sat` = 1 the result is then 0x00007FFF. With `frac_sat` = 0 the result is the low 16 bits (0x0000). When there is no carry, the rounded value is output unchanged in both cases.
- R7: In wide fractional mode, if the shifted and rounded value has any bit set above bit 31, the result is 0x7FFFFFFF when `frac_sat` = 1 and the low 32 bits when `frac_sat` = 0. Otherwise the result is the low 32 bits in both cases.
- R8: Signed integer mode (`rd_mode` = 1): if bits 63..31 are all equal, the result is bits 31..0. Otherwise the result is 0x80000000 when bit 63 is 1 and 0x7FFFFFFF when bit 63 is 0.
- R9: Unsigned integer mode (`rd_mode` = 2, with code 3 acting the same): if bits 63..32 are all zero, the result is bits 31..0. Otherwise it is 0xFFFFFFFF.
- R10: In both integer modes, `frac_half`, `frac_round` and `frac_sat` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe; captures a formatted result |
| rd_mode | input | 2 | 0 fractional, 1 signed integer, 2/3 unsigned integer |
| frac_half | input | 1 | Fractional: 16-bit result with rounding on bits 23..0 |
| frac_round | input | 1 | Fractional wide: enable convergent rounding on bits 7..0 |
| frac_sat | input | 1 | Fractional: clamp results that do not fit |
| acc_in | input | 64 | Accumulator value |
| rd_data | output | 32 | Registered formatted result |

## Verification
Assertions check on every cycle the behaviour that can be read from the ports without knowing the arithmetic. The output holds between strobes. A half-width read leaves the upper half zero. A negative signed read yields a negative word. An out-of-range unsigned read yields all ones. Only the bench's scenarios can show the exact rounding values: ties broken toward even, and carries out of the kept field that trigger clamping. The same holds for the clamp constants and for the cycle in which the result appears.

// File: rtl/acrf_pkg.sv
`timescale 1ns/1ps
package acrf_pkg;
  localparam int ACRF_ACC_W       = 64;
  localparam int ACRF_OUT_W       = 32;
  localparam int ACRF_HALF_W      = 16;
  localparam int ACRF_HALF_DROP   = 24;
  localparam int ACRF_WIDE_DROP   = 8;

  typedef enum logic [1:0] {
    ACRF_FRAC     = 2'd0,
    ACRF_SINT     = 2'd1,
    ACRF_UINT     = 2'd2,
    ACRF_UINT_ALT = 2'd3
  } acrf_mode_e;
endpackage

// File: rtl/acrf_conv_round.sv
`timescale 1ns/1ps
// Drops DROP low bits and rounds half-to-even; one extra output bit keeps the carry.
module acrf_conv_round #(
  parameter int IN_W = 40,
  parameter int DROP = 24
) (
  input  logic [IN_W-1:0]    val_i,
  input  logic               rnd_en_i,
  output logic [IN_W-DROP:0] rnd_o
);
  localparam int KEEP_W = IN_W - DROP;
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

  logic [KEEP_W-1:0] kept;
  logic [DROP-1:0]   rem;
  logic              bump;

  always_comb begin
    kept  = val_i[IN_W-1:DROP];
    rem   = val_i[DROP-1:0];
    bump  = rnd_en_i && ((rem > HALF) || ((rem == HALF) && kept[0]));
    rnd_o = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};
  end
endmodule

// File: rtl/acrf_range_clamp.sv
`timescale 1ns/1ps
// Passes the low OUT_W bits, or the largest positive OUT_W value when clamping is on and the input does not fit.
module acrf_range_clamp #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             sat_en_i,
  output logic [OUT_W-1:0] res_o
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  logic fits;

  always_comb begin
    fits  = ~|val_i[IN_W-1:OUT_W];
    res_o = (sat_en_i && !fits) ? POS_MAX : val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/acrf_frac_path.sv
`timescale 1ns/1ps
module acrf_frac_path
  import acrf_pkg::*;
#(
  parameter int ACC_W     = ACRF_ACC_W,
  parameter int OUT_W     = ACRF_OUT_W,
  parameter int HALF_W    = ACRF_HALF_W,
  parameter int HALF_DROP = ACRF_HALF_DROP,
  parameter int WIDE_DROP = ACRF_WIDE_DROP
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             half_i,
  input  logic             rnd_en_i,
  input  logic             sat_en_i,
  output logic [OUT_W-1:0] res_o
);
  localparam int HALF_IN_W = HALF_W + HALF_DROP;
  localparam int WIDE_KEEP = ACC_W - WIDE_DROP;

  logic [HALF_W:0]    rnd_half;
  logic [HALF_W-1:0]  res_half;
  logic [WIDE_KEEP:0] rnd_wide;
  logic [OUT_W-1:0]   res_wide;

  // Half-width view always rounds.
  acrf_conv_round #(.IN_W(HALF_IN_W), .DROP(HALF_DROP)) u_rnd_half (
    .val_i    (acc_i[HALF_IN_W-1:0]),
    .rnd_en_i (1'b1),
    .rnd_o    (rnd_half)
  );

  acrf_range_clamp #(.IN_W(HALF_W+1), .OUT_W(HALF_W)) u_clamp_half (
    .val_i    (rnd_half),
    .sat_en_i (sat_en_i),
    .res_o    (res_half)
  );

  acrf_conv_round #(.IN_W(ACC_W), .DROP(WIDE_DROP)) u_rnd_wide (
    .val_i    (acc_i),
    .rnd_en_i (rnd_en_i),
    .rnd_o    (rnd_wide)
  );

  acrf_range_clamp #(.IN_W(WIDE_KEEP+1), .OUT_W(OUT_W)) u_clamp_wide (
    .val_i    (rnd_wide),
    .sat_en_i (sat_en_i),
    .res_o    (res_wide)
  );

  always_comb begin
    res_o = half_i ? {{(OUT_W-HALF_W){1'b0}}, res_half} : res_wide;
  end
endmodule

// File: rtl/acrf_int_clamp.sv
`timescale 1ns/1ps
module acrf_int_clamp
  import acrf_pkg::*;
#(
  parameter int ACC_W = ACRF_ACC_W,
  parameter int OUT_W = ACRF_OUT_W
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] sint_o,
  output logic [OUT_W-1:0] uint_o
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [ACC_W-OUT_W:0] sign_span;
  logic                 s_fits;
  logic                 u_fits;

  always_comb begin
    sign_span = acc_i[ACC_W-1:OUT_W-1];
    s_fits    = (&sign_span) | ~(|sign_span);
    u_fits    = ~|acc_i[ACC_W-1:OUT_W];
    sint_o    = s_fits ? acc_i[OUT_W-1:0] : (acc_i[ACC_W-1] ? NEG_MIN : POS_MAX);
    uint_o    = u_fits ? acc_i[OUT_W-1:0] : {OUT_W{1'b1}};
  end
endmodule

// File: rtl/acc_readout_fmt.sv
`timescale 1ns/1ps
module acc_readout_fmt
  import acrf_pkg::*;
#(
  parameter int ACC_W     = ACRF_ACC_W,
  parameter int OUT_W     = ACRF_OUT_W,
  parameter int HALF_W    = ACRF_HALF_W,
  parameter int HALF_DROP = ACRF_HALF_DROP,
  parameter int WIDE_DROP = ACRF_WIDE_DROP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [1:0]       rd_mode,
  input  logic             frac_half,
  input  logic             frac_round,
  input  logic             frac_sat,
  input  logic [ACC_W-1:0] acc_in,
  output logic [OUT_W-1:0] rd_data
);
  acrf_mode_e       mode_e;
  logic [OUT_W-1:0] frac_res;
  logic [OUT_W-1:0] sint_res;
  logic [OUT_W-1:0] uint_res;
  logic [OUT_W-1:0] next_res;

  acrf_frac_path #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W),
    .HALF_DROP(HALF_DROP), .WIDE_DROP(WIDE_DROP)
  ) u_frac (
    .acc_i    (acc_in),
    .half_i   (frac_half),
    .rnd_en_i (frac_round),
    .sat_en_i (frac_sat),
    .res_o    (frac_res)
  );

  acrf_int_clamp #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_int (
    .acc_i  (acc_in),
    .sint_o (sint_res),
    .uint_o (uint_res)
  );

  always_comb begin
    mode_e = acrf_mode_e'(rd_mode);
    case (mode_e)
      ACRF_FRAC: next_res = frac_res;
      ACRF_SINT: next_res = sint_res;
      default:   next_res = uint_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= next_res;
  end

  // R2
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode == 2'd0 && frac_half) |=> (rd_data[OUT_W-1:HALF_W] == '0));

  // R8
  signed_neg_keeps_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode == 2'd1 && acc_in[ACC_W-1]) |=> rd_data[OUT_W-1]);

  // R9
  unsigned_over_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode[1] && (|acc_in[ACC_W-1:OUT_W])) |=> (&rd_data));
endmodule

// File: tb/acc_readout_fmt_tb_top.sv
`timescale 1ns/1ps
module acc_readout_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_mode = 2'd0;
  logic        frac_half = 1'b0;
  logic        frac_round = 1'b0;
  logic        frac_sat = 1'b0;
  logic [63:0] acc_in = 64'd0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_readout_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
    .frac_half(frac_half), .frac_round(frac_round), .frac_sat(frac_sat),
    .acc_in(acc_in), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  // Strobe for one cycle, then sample at the following falling edge.
  task automatic rd(input logic [1:0] m, input logic h, input logic r, input logic s,
                    input logic [63:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    rd_mode = m; frac_half = h; frac_round = r; frac_sat = s; acc_in = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", rd_data, 32'h0);
  endtask

  task automatic t_half_round;
    rd(2'd0, 1'b1, 1'b1, 1'b0, 64'h0000_0012_347F_FFFF, "R3 below half", 32'h0000_1234);
    rd(2'd0, 1'b1, 1'b1, 1'b0, 64'h0000_0012_3480_0001, "R3 above half", 32'h0000_1235);
    rd(2'd0, 1'b1, 1'b1, 1'b0, 64'h0000_0012_3480_0000, "R3 tie even", 32'h0000_1234);
    rd(2'd0, 1'b1, 1'b1, 1'b0, 64'h0000_0012_3580_0000, "R3 tie odd", 32'h0000_1236);
    rd(2'd0, 1'b1, 1'b1, 1'b0, 64'hABCD_EF12_3400_0000, "R3 high bits ignored", 32'h0000_1234);
    rd(2'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0012_3480_0001, "R3 round enable ignored", 32'h0000_1235);
  endtask

  task automatic t_wide_round;
    rd(2'd0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_1234_5680, "R4 tie even", 32'h0012_3456);
    rd(2'd0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_1234_5780, "R4 tie odd", 32'h0012_3458);
    rd(2'd0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_1234_5681, "R4 above half", 32'h0012_3457);
    rd(2'd0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_1234_567F, "R4 below half", 32'h0012_3456);
  endtask

  task automatic t_wide_trunc;
    rd(2'd0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_1234_56FF, "R5 truncate", 32'h0012_3456);
    rd(2'd0, 1'b0, 1'b0, 1'b1, 64'h0000_00AB_CDEF_0100, "R5 full width fits", 32'hABCD_EF01);
  endtask

  task automatic t_half_sat;
    rd(2'd0, 1'b1, 1'b0, 1'b1, 64'h0000_00FF_FF80_0000, "R6 carry clamped", 32'h0000_7FFF);
    rd(2'd0, 1'b1, 1'b0, 1'b0, 64'h0000_00FF_FF80_0000, "R6 carry wraps", 32'h0000_0000);
    rd(2'd0, 1'b1, 1'b0, 1'b1, 64'h0000_00FF_FF00_0000, "R6 no carry", 32'h0000_FFFF);
  endtask

  task automatic t_wide_sat;
    rd(2'd0, 1'b0, 1'b0, 1'b1, 64'h0000_0100_0000_0000, "R7 over clamped", 32'h7FFF_FFFF);
    rd(2'd0, 1'b0, 1'b0, 1'b0, 64'h0000_0100_0000_0000, "R7 over wraps", 32'h0000_0000);
    rd(2'd0, 1'b0, 1'b1, 1'b1, 64'h0000_00FF_FFFF_FF80, "R7 rounding carry clamped", 32'h7FFF_FFFF);
    rd(2'd0, 1'b0, 1'b1, 1'b0, 64'h0000_00FF_FFFF_FF80, "R7 rounding carry wraps", 32'h0000_0000);
    rd(2'd0, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, "R7 top bits set clamped", 32'h7FFF_FFFF);
  endtask

  task automatic t_signed;
    rd(2'd1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, "R8 max positive", 32'h7FFF_FFFF);
    rd(2'd1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, "R8 min negative", 32'h8000_0000);
    rd(2'd1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_8000_0000, "R8 positive over", 32'h7FFF_FFFF);
    rd(2'd1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, "R8 negative over", 32'h8000_0000);
    rd(2'd1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, "R8 small negative", 32'hFFFF_FFFE);
  endtask

  task automatic t_unsigned;
    rd(2'd2, 1'b0, 1'b0, 1'b0, 64'h0000_0000_DEAD_BEEF, "R9 fits", 32'hDEAD_BEEF);
    rd(2'd2, 1'b0, 1'b0, 1'b0, 64'h0000_0001_0000_0000, "R9 over low", 32'hFFFF_FFFF);
    rd(2'd2, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0005, "R9 over top", 32'hFFFF_FFFF);
    rd(2'd3, 1'b0, 1'b0, 1'b0, 64'h0000_0000_1234_5678, "R9 code 3 fits", 32'h1234_5678);
    rd(2'd3, 1'b0, 1'b0, 1'b0, 64'h0000_0002_0000_0000, "R9 code 3 over", 32'hFFFF_FFFF);
  endtask

  task automatic t_int_ignores_frac;
    rd(2'd1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_1234_5678, "R10 signed with frac bits", 32'h1234_5678);
    rd(2'd2, 1'b1, 1'b1, 1'b1, 64'h0000_0000_8765_4321, "R10 unsigned with frac bits", 32'h8765_4321);
  endtask

  task automatic t_hold;
    rd(2'd3, 1'b0, 1'b0, 1'b0, 64'h0000_0000_CAFE_F00D, "R2 load", 32'hCAFE_F00D);
    @(negedge clk);
    rd_mode = 2'd0; frac_half = 1'b1; frac_sat = 1'b1; acc_in = 64'h1111_2222_3333_4444;
    repeat (3) @(negedge clk);
    chk("R2 hold without strobe", rd_data, 32'hCAFE_F00D);
    acc_in = 64'h0;
    @(negedge clk);
    chk("R2 hold after second change", rd_data, 32'hCAFE_F00D);
  endtask

  initial begin
    t_reset();
    t_half_round();
    t_wide_round();
    t_wide_trunc();
    t_half_sat();
    t_wide_sat();
    t_signed();
    t_unsigned();
    t_int_ignores_frac();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule